// File: doc/BRIEF.md
# JTAG Debug Transport Bridge

This block is a JTAG test access port through which an external probe reaches a debug-module register bus. The port runs on the test clock and holds the standard sixteen-state TAP controller, a 5-bit instruction register and three selectable data registers: an identification word, a transport control/status word and a bus-access word. A bus-access scan that carries a read or write operation starts one request. The request crosses into the debug clock domain, and its response comes back to the test clock domain. Each direction crosses with a single toggle line, and the payload is held still while the toggle is in flight.

The transport keeps a sticky status. It records two cases: a probe that scans the access register again before the previous request has answered (overrun, reported as busy), and a request that the bus answered with a failure. While the sticky status is set, all further requests are dropped. Two command bits in the control/status word recover the port. The soft command clears the sticky status. The hard command also abandons the request in flight, and the response to that request is thrown away when it arrives.

TAP states, as used in the RTL: TLR (test-logic-reset), RTI (run-test/idle), SEL_DR, CAP_DR, SH_DR, EX1_DR, PA_DR, EX2_DR, UPD_DR, and the matching SEL_IR, CAP_IR, SH_IR, EX1_IR, PA_IR, EX2_IR, UPD_IR. The TMS value decides each transition:
- TLR goes to RTI on 0 and stays on 1.
- RTI stays on 0 and goes to SEL_DR on 1.
- SEL_DR goes to CAP_DR on 0 and to SEL_IR on 1.
- SEL_IR goes to CAP_IR on 0 and to TLR on 1.
- CAP goes to SH on 0 and to EX1 on 1.
- SH stays on 0 and goes to EX1 on 1.
- EX1 goes to PA on 0 and to UPD on 1.
- PA stays on 0 and goes to EX2 on 1.
- EX2 goes to SH on 0 and to UPD on 1.
- UPD goes to RTI on 0 and to SEL_DR on 1.

The debug-side handshake has two states. DS_IDLE goes to DS_WAIT when a new request toggle is seen, and it pulses the request outputs as it does. DS_WAIT goes back to DS_IDLE when a response is valid, and it flips the response toggle as it does.

Top module: `jtag_dtm`

## Requirements
- R1: When trst_n is low, or after five consecutive TCK rising edges with tms high, the TAP is in test-logic-reset and the instruction becomes 0x01 (identification). tdo is 0 in every state other than Shift-IR and Shift-DR.
- R2: The instruction register is 5 bits wide and shifts LSB first. Capture-IR loads 5'b00001, and the shifted code takes effect only at Update-IR.
- R3: Instruction 0x01 selects a 32-bit register that captures the IDCODE_VALUE parameter.
- R4: Instruction 0x10 selects a 32-bit control/status word. On capture, bits [3:0]=1 (version), [9:4]=ABITS, [11:10]=sticky status and [14:12]=IDLE_HINT; every other bit is 0.
- R5: Instruction 0x11 selects an access register of ABITS+34 bits, with bits [1:0] op, [33:2] data and [ABITS+33:34] address. Capture loads the address of the last issued request, the last accepted response data and a status code in op: 0 success, 2 failed, 3 busy.
- R6: At Update-DR of the access register, op 1 (read) or op 2 (write) issues exactly one request if no sticky status is set and nothing is outstanding. The request is a one-cycle dmi_req_valid pulse on dbg_clk carrying the address, the data and dmi_req_write = (op==2). Op 0 issues nothing.
- R7: Capturing the access register while a request is outstanding returns op 3 and sets the sticky status to busy (3).
- R8: While the sticky status is non-zero, Update-DR issues no request and Capture-DR returns the sticky code.
- R9: Writing 1 to bit 16 of the control/status word at Update-DR clears the sticky status to 0.
- R10: A response with dmi_rsp_fail high sets the sticky status to failed (2). Its data is still latched as the last response data.
- R11: Writing 1 to bit 17 of the control/status word clears the sticky status and abandons the outstanding request. The response to that request is discarded. Until it arrives, captures return op 3 without making it sticky, and new requests are dropped.
- R12: Any instruction other than 0x01, 0x10 and 0x11 (including 0x1F) selects a 1-bit bypass register that captures 0.
- R13: At most one request is in flight between the clock domains, and its address, data and op stay unchanged until its response returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Test data in |
| tdo | output | 1 | Test data out, LSB of the active shift register |
| dbg_clk | input | 1 | Debug-domain clock |
| dbg_rst_n | input | 1 | Debug-domain asynchronous reset, active low |
| dmi_req_valid | output | 1 | One-cycle request strobe |
| dmi_req_addr | output | ABITS | Request register address |
| dmi_req_data | output | 32 | Request write data |
| dmi_req_write | output | 1 | 1 for write, 0 for read |
| dmi_rsp_valid | input | 1 | Response strobe, accepted after the request strobe |
| dmi_rsp_data | input | 32 | Response read data |
| dmi_rsp_fail | input | 1 | Response reports failure |

## Verification
A wrong TAP state or a wrong instruction shows on tdo within the same scan: bits shifted out at the wrong clock, or from the wrong register. A corrupted sticky status or a corrupted outstanding flag shows at the next capture of the access register or of the control/status word, as a wrong status code. It also shows on the debug side as a request that is missing or extra, so the bench counts the bus strobes it receives. A lost toggle or a duplicated toggle leaves the port busy for ever, or lets a second request overtake the first. The busy, failure and abandon sequences are driven on purpose, with both short and long response latency.

// File: rtl/dtm_pkg.sv
package dtm_pkg;
    localparam int IR_W = 5;
    localparam logic [IR_W-1:0] IR_IDCODE  = 5'h01;
    localparam logic [IR_W-1:0] IR_CTRL    = 5'h10;
    localparam logic [IR_W-1:0] IR_ACCESS  = 5'h11;
    localparam logic [IR_W-1:0] IR_CAPTURE = 5'b00001;

    localparam logic [1:0] OP_NOP   = 2'd0;
    localparam logic [1:0] OP_READ  = 2'd1;
    localparam logic [1:0] OP_WRITE = 2'd2;

    localparam logic [1:0] ST_OK   = 2'd0;
    localparam logic [1:0] ST_FAIL = 2'd2;
    localparam logic [1:0] ST_BUSY = 2'd3;

    localparam int CTRL_SOFT_BIT = 16;
    localparam int CTRL_HARD_BIT = 17;

    typedef enum logic [3:0] {
        TLR, RTI,
        SEL_DR, CAP_DR, SH_DR, EX1_DR, PA_DR, EX2_DR, UPD_DR,
        SEL_IR, CAP_IR, SH_IR, EX1_IR, PA_IR, EX2_IR, UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {
        DR_IDCODE, DR_CTRL, DR_ACCESS, DR_BYPASS
    } dr_sel_e;

    typedef enum logic {
        DS_IDLE, DS_WAIT
    } dbg_state_e;
endpackage

// File: rtl/dtm_sync2.sv
module dtm_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic meta_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            q      <= 1'b0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/dtm_tap_fsm.sv
module dtm_tap_fsm import dtm_pkg::*; (
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state_o
);
    tap_state_e state_q, state_d;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state_q <= TLR;
        else         state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            TLR:    state_d = tms ? TLR    : RTI;
            RTI:    state_d = tms ? SEL_DR : RTI;
            SEL_DR: state_d = tms ? SEL_IR : CAP_DR;
            CAP_DR: state_d = tms ? EX1_DR : SH_DR;
            SH_DR:  state_d = tms ? EX1_DR : SH_DR;
            EX1_DR: state_d = tms ? UPD_DR : PA_DR;
            PA_DR:  state_d = tms ? EX2_DR : PA_DR;
            EX2_DR: state_d = tms ? UPD_DR : SH_DR;
            UPD_DR: state_d = tms ? SEL_DR : RTI;
            SEL_IR: state_d = tms ? TLR    : CAP_IR;
            CAP_IR: state_d = tms ? EX1_IR : SH_IR;
            SH_IR:  state_d = tms ? EX1_IR : SH_IR;
            EX1_IR: state_d = tms ? UPD_IR : PA_IR;
            PA_IR:  state_d = tms ? EX2_IR : PA_IR;
            EX2_IR: state_d = tms ? UPD_IR : SH_IR;
            UPD_IR: state_d = tms ? SEL_DR : RTI;
            default: state_d = TLR;
        endcase
    end

    assign state_o = state_q;

    // R1: five TMS-high clocks always land in test-logic-reset
    assert_tms_reset_R1: assert property (@(posedge tck) disable iff (!trst_n)
        ($past(tms, 1) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4) && $past(tms, 5))
        |-> (state_q == TLR));
endmodule

// File: rtl/dtm_dbg_side.sv
module dtm_dbg_side import dtm_pkg::*; #(
    parameter int ABITS = 7
) (
    input  logic             dbg_clk,
    input  logic             dbg_rst_n,
    input  logic             req_tgl_i,
    input  logic [ABITS-1:0] req_addr_i,
    input  logic [31:0]      req_data_i,
    input  logic [1:0]       req_op_i,
    output logic             dmi_req_valid,
    output logic [ABITS-1:0] dmi_req_addr,
    output logic [31:0]      dmi_req_data,
    output logic             dmi_req_write,
    input  logic             dmi_rsp_valid,
    input  logic [31:0]      dmi_rsp_data,
    input  logic             dmi_rsp_fail,
    output logic             rsp_tgl_o,
    output logic [31:0]      rsp_data_o,
    output logic             rsp_fail_o
);
    dbg_state_e state_q, state_d;
    logic req_s, seen_q, new_req;

    dtm_sync2 u_req_sync (.clk(dbg_clk), .rst_n(dbg_rst_n), .d(req_tgl_i), .q(req_s));

    assign new_req = (req_s != seen_q);

    always_ff @(posedge dbg_clk or negedge dbg_rst_n) begin
        if (!dbg_rst_n) state_q <= DS_IDLE;
        else            state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            DS_IDLE: state_d = new_req       ? DS_WAIT : DS_IDLE;
            DS_WAIT: state_d = dmi_rsp_valid ? DS_IDLE : DS_WAIT;
            default: state_d = DS_IDLE;
        endcase
    end

    always_ff @(posedge dbg_clk or negedge dbg_rst_n) begin
        if (!dbg_rst_n) begin
            seen_q        <= 1'b0;
            dmi_req_valid <= 1'b0;
            dmi_req_addr  <= '0;
            dmi_req_data  <= '0;
            dmi_req_write <= 1'b0;
            rsp_tgl_o     <= 1'b0;
            rsp_data_o    <= '0;
            rsp_fail_o    <= 1'b0;
        end else begin
            dmi_req_valid <= 1'b0;
            if (state_q == DS_IDLE && new_req) begin
                seen_q        <= req_s;
                dmi_req_valid <= 1'b1;
                dmi_req_addr  <= req_addr_i;
                dmi_req_data  <= req_data_i;
                dmi_req_write <= (req_op_i == OP_WRITE);
            end
            if (state_q == DS_WAIT && dmi_rsp_valid) begin
                rsp_data_o <= dmi_rsp_data;
                rsp_fail_o <= dmi_rsp_fail;
                rsp_tgl_o  <= ~rsp_tgl_o;
            end
        end
    end

    // R6: every request strobe lasts exactly one debug clock
    assert_req_pulse_R6: assert property (@(posedge dbg_clk) disable iff (!dbg_rst_n)
        dmi_req_valid |=> !dmi_req_valid);
endmodule

// File: rtl/jtag_dtm.sv
module jtag_dtm import dtm_pkg::*; #(
    parameter int          ABITS        = 7,
    parameter logic [31:0] IDCODE_VALUE = 32'h1A2B_3C4D,
    parameter int          IDLE_HINT    = 2
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tms,
    input  logic             tdi,
    output logic             tdo,
    input  logic             dbg_clk,
    input  logic             dbg_rst_n,
    output logic             dmi_req_valid,
    output logic [ABITS-1:0] dmi_req_addr,
    output logic [31:0]      dmi_req_data,
    output logic             dmi_req_write,
    input  logic             dmi_rsp_valid,
    input  logic [31:0]      dmi_rsp_data,
    input  logic             dmi_rsp_fail
);
    localparam int DR_W = ABITS + 34;
    localparam logic [5:0] ABITS_F = 6'(ABITS);
    localparam logic [2:0] IDLE_F  = 3'(IDLE_HINT);

    tap_state_e tap_state;
    dr_sel_e    dr_sel;
    int         dr_len;

    logic [IR_W-1:0]  ir_q, ir_sr_q;
    logic [DR_W-1:0]  sr_q, sr_shifted;
    logic [DR_W:0]    sr_ext;
    logic [1:0]       sticky_q, access_status;
    logic             abandon_q, req_tgl_q, rsp_prev_q, rsp_sync, hw_busy, rsp_done;
    logic [ABITS-1:0] req_addr_q;
    logic [31:0]      req_data_q, last_data_q, ctrl_cap, rsp_data_x;
    logic [1:0]       req_op_q;
    logic             rsp_tgl_x, rsp_fail_x;

    dtm_tap_fsm u_tap (.tck(tck), .trst_n(trst_n), .tms(tms), .state_o(tap_state));

    dtm_dbg_side #(.ABITS(ABITS)) u_dbg (
        .dbg_clk(dbg_clk), .dbg_rst_n(dbg_rst_n),
        .req_tgl_i(req_tgl_q), .req_addr_i(req_addr_q), .req_data_i(req_data_q), .req_op_i(req_op_q),
        .dmi_req_valid(dmi_req_valid), .dmi_req_addr(dmi_req_addr),
        .dmi_req_data(dmi_req_data), .dmi_req_write(dmi_req_write),
        .dmi_rsp_valid(dmi_rsp_valid), .dmi_rsp_data(dmi_rsp_data), .dmi_rsp_fail(dmi_rsp_fail),
        .rsp_tgl_o(rsp_tgl_x), .rsp_data_o(rsp_data_x), .rsp_fail_o(rsp_fail_x)
    );

    dtm_sync2 u_rsp_sync (.clk(tck), .rst_n(trst_n), .d(rsp_tgl_x), .q(rsp_sync));

    assign hw_busy  = (req_tgl_q != rsp_sync);
    assign rsp_done = (rsp_sync != rsp_prev_q);

    // instruction register
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            ir_q    <= IR_IDCODE;
            ir_sr_q <= '0;
        end else begin
            unique case (tap_state)
                TLR:     ir_q    <= IR_IDCODE;
                CAP_IR:  ir_sr_q <= IR_CAPTURE;
                SH_IR:   ir_sr_q <= {tdi, ir_sr_q[IR_W-1:1]};
                UPD_IR:  ir_q    <= ir_sr_q;
                default: ;
            endcase
        end
    end

    // data register selection and length
    always_comb begin
        unique case (ir_q)
            IR_IDCODE: begin dr_sel = DR_IDCODE; dr_len = 32;   end
            IR_CTRL:   begin dr_sel = DR_CTRL;   dr_len = 32;   end
            IR_ACCESS: begin dr_sel = DR_ACCESS; dr_len = DR_W; end
            default:   begin dr_sel = DR_BYPASS; dr_len = 1;    end
        endcase
    end

    assign sr_ext = {1'b0, sr_q};
    always_comb begin
        for (int i = 0; i < DR_W; i++) begin
            if (i == dr_len - 1)     sr_shifted[i] = tdi;
            else if (i < dr_len - 1) sr_shifted[i] = sr_ext[i+1];
            else                     sr_shifted[i] = 1'b0;
        end
    end

    assign access_status = (sticky_q != ST_OK) ? sticky_q : (hw_busy ? ST_BUSY : ST_OK);
    assign ctrl_cap = {14'd0, 1'b0, 1'b0, 1'b0, IDLE_F, sticky_q, ABITS_F, 4'd1};

    // data registers, sticky status and request issue
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            sr_q        <= '0;
            sticky_q    <= ST_OK;
            abandon_q   <= 1'b0;
            req_tgl_q   <= 1'b0;
            req_addr_q  <= '0;
            req_data_q  <= '0;
            req_op_q    <= OP_NOP;
            last_data_q <= '0;
            rsp_prev_q  <= 1'b0;
        end else begin
            rsp_prev_q <= rsp_sync;
            if (rsp_done) begin
                if (!abandon_q) begin
                    last_data_q <= rsp_data_x;
                    if (rsp_fail_x) sticky_q <= ST_FAIL;
                end
                abandon_q <= 1'b0;
            end
            unique case (tap_state)
                CAP_DR: begin
                    unique case (dr_sel)
                        DR_IDCODE: sr_q <= DR_W'(IDCODE_VALUE);
                        DR_CTRL:   sr_q <= DR_W'(ctrl_cap);
                        DR_ACCESS: begin
                            sr_q <= {req_addr_q, last_data_q, access_status};
                            if (hw_busy && !abandon_q && sticky_q == ST_OK) sticky_q <= ST_BUSY;
                        end
                        default:   sr_q <= '0;
                    endcase
                end
                SH_DR: sr_q <= sr_shifted;
                UPD_DR: begin
                    if (dr_sel == DR_CTRL) begin
                        if (sr_q[CTRL_SOFT_BIT]) sticky_q <= ST_OK;
                        if (sr_q[CTRL_HARD_BIT]) begin
                            sticky_q  <= ST_OK;
                            abandon_q <= hw_busy;
                        end
                    end else if (dr_sel == DR_ACCESS && sticky_q == ST_OK && !hw_busy &&
                                 (sr_q[1:0] == OP_READ || sr_q[1:0] == OP_WRITE)) begin
                        req_addr_q <= sr_q[DR_W-1:34];
                        req_data_q <= sr_q[33:2];
                        req_op_q   <= sr_q[1:0];
                        req_tgl_q  <= ~req_tgl_q;
                    end
                end
                default: ;
            endcase
        end
    end

    // output process
    always_comb begin
        unique case (tap_state)
            SH_IR:   tdo = ir_sr_q[0];
            SH_DR:   tdo = sr_q[0];
            default: tdo = 1'b0;
        endcase
    end

    // R2: instruction changes only at Update-IR or in reset state
    assert_ir_update_R2: assert property (@(posedge tck) disable iff (!trst_n)
        !(tap_state == UPD_IR || tap_state == TLR) |=> $stable(ir_q));

    // R8: a sticky status blocks any new request
    assert_sticky_blocks_R8: assert property (@(posedge tck) disable iff (!trst_n)
        (sticky_q != ST_OK) |=> $stable(req_tgl_q));

    // R13: payload is held while a request is in flight
    assert_payload_hold_R13: assert property (@(posedge tck) disable iff (!trst_n)
        hw_busy |=> ($stable(req_addr_q) && $stable(req_data_q) && $stable(req_op_q)));

    // R7: capturing the access register during a live request marks busy
    assert_overrun_R7: assert property (@(posedge tck) disable iff (!trst_n)
        (tap_state == CAP_DR && dr_sel == DR_ACCESS && hw_busy && !abandon_q && sticky_q == ST_OK)
        |=> (sticky_q == ST_BUSY));
endmodule

// File: tb/jtag_dtm_tb_top.sv
module jtag_dtm_tb_top;
    localparam int ABITS = 7;
    localparam logic [31:0] IDV = 32'h1A2B_3C4D;

    logic tck = 0, dbg_clk = 0;
    logic trst_n = 0, dbg_rst_n = 0, tms = 1, tdi = 0;
    logic tdo;
    logic dmi_req_valid, dmi_req_write;
    logic [ABITS-1:0] dmi_req_addr;
    logic [31:0] dmi_req_data;
    logic dmi_rsp_valid = 0, dmi_rsp_fail = 0;
    logic [31:0] dmi_rsp_data = 0;

    int checks = 0, failures = 0;
    int lat = 2, req_count = 0;
    logic [31:0] mem [128];
    logic [6:0] last_addr; logic [31:0] last_wdata; logic last_write;

    always #10 tck = ~tck;
    always #7 dbg_clk = ~dbg_clk;

    jtag_dtm #(.ABITS(ABITS), .IDCODE_VALUE(IDV), .IDLE_HINT(2)) dut_i (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
        .dbg_clk(dbg_clk), .dbg_rst_n(dbg_rst_n),
        .dmi_req_valid(dmi_req_valid), .dmi_req_addr(dmi_req_addr),
        .dmi_req_data(dmi_req_data), .dmi_req_write(dmi_req_write),
        .dmi_rsp_valid(dmi_rsp_valid), .dmi_rsp_data(dmi_rsp_data), .dmi_rsp_fail(dmi_rsp_fail));

    // behavioural debug-bus responder: memory, failure at address 0x7F
    initial begin
        for (int i = 0; i < 128; i++) mem[i] = 32'd0;
        forever begin
            @(negedge dbg_clk);
            if (dmi_req_valid) begin
                req_count++;
                last_addr = dmi_req_addr; last_wdata = dmi_req_data; last_write = dmi_req_write;
                repeat (lat) @(negedge dbg_clk);
                dmi_rsp_fail = (last_addr == 7'h7F);
                if (last_addr == 7'h7F) dmi_rsp_data = 32'd0;
                else if (last_write) begin mem[last_addr] = last_wdata; dmi_rsp_data = 32'd0; end
                else dmi_rsp_data = mem[last_addr];
                dmi_rsp_valid = 1;
                @(negedge dbg_clk);
                dmi_rsp_valid = 0; dmi_rsp_fail = 0;
            end
        end
    end

    task automatic report;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (150000) @(posedge tck);
        failures++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        report();
        $finish;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // one TCK: compare tdo with the model's expectation, then drive
    task automatic tick(input logic tms_v, input logic tdi_v, input logic exp_v,
                        output logic got_v, inout int bad);
        @(negedge tck);
        got_v = tdo;
        if (tdo !== exp_v) bad++;
        tms = tms_v; tdi = tdi_v;
    endtask

    task automatic idle(input int n);
        logic g; int b = 0;
        for (int i = 0; i < n; i++) tick(0, 0, 0, g, b);
        check(b == 0, "R1", "tdo low outside shift", 64'(b), 64'd0);
    endtask

    task automatic scan_ir(input logic [4:0] code);
        logic g; int b = 0; logic [63:0] got = 0;
        tick(1, 0, 0, g, b); tick(1, 0, 0, g, b); tick(0, 0, 0, g, b); tick(0, 0, 0, g, b);
        for (int i = 0; i < 5; i++) begin
            tick(i == 4, code[i], (i == 0), g, b);
            got[i] = g;
        end
        tick(1, 0, 0, g, b); tick(0, 0, 0, g, b);
        check(b == 0, "R2", "IR capture 00001", got, 64'd1);
    endtask

    task automatic scan_dr(input int len, input logic [63:0] din, input logic [63:0] exp,
                           input string req);
        logic g; int b = 0; logic [63:0] got = 0;
        tick(1, 0, 0, g, b); tick(0, 0, 0, g, b); tick(0, 0, 0, g, b);
        for (int i = 0; i < len; i++) begin
            tick(i == len - 1, din[i], exp[i], g, b);
            got[i] = g;
        end
        tick(1, 0, 0, g, b); tick(0, 0, 0, g, b);
        check(b == 0, req, "DR scan out", got, exp);
    endtask

    function automatic logic [63:0] acc(input logic [6:0] a, input logic [31:0] d, input logic [1:0] op);
        return {23'd0, a, d, op};
    endfunction
    function automatic logic [63:0] ctl(input logic [1:0] st);
        return 64'((32'd2 << 12) | (32'(st) << 10) | (32'd7 << 4) | 32'd1);
    endfunction

    localparam int AW = ABITS + 34;
    int rc;

    initial begin
        repeat (3) @(negedge tck);
        trst_n = 1; dbg_rst_n = 1;
        idle(1);
        // R1 R3: reset instruction selects the identification code
        scan_dr(32, 0, 64'(IDV), "R3");

        // R4: control/status word
        scan_ir(5'h10);
        scan_dr(32, 0, ctl(2'd0), "R4");

        // R5 R6: write then read through the access register
        scan_ir(5'h11);
        scan_dr(AW, acc(7'h05, 32'hDEAD_BEEF, 2'd2), acc(0, 0, 0), "R5");
        idle(12);
        check(req_count == 1 && last_write && last_addr == 7'h05 && last_wdata == 32'hDEAD_BEEF,
              "R6", "write request on bus", {last_write, last_addr, last_wdata}, {1'b1, 7'h05, 32'hDEAD_BEEF});
        scan_dr(AW, acc(7'h05, 0, 2'd1), acc(7'h05, 0, 0), "R5");
        idle(12);
        check(req_count == 2 && !last_write, "R6", "read request on bus", 64'(req_count), 64'd2);
        scan_dr(AW, acc(0, 0, 0), acc(7'h05, 32'hDEAD_BEEF, 0), "R5");
        idle(12);
        check(req_count == 2, "R6", "nop issues nothing", 64'(req_count), 64'd2);

        // R7 R8 R9: overrun makes busy sticky, requests dropped, soft clear
        lat = 300;
        scan_dr(AW, acc(7'h05, 0, 2'd1), acc(7'h05, 32'hDEAD_BEEF, 0), "R6");
        idle(2);
        scan_dr(AW, acc(0, 0, 0), acc(7'h05, 32'hDEAD_BEEF, 2'd3), "R7");
        scan_dr(AW, acc(7'h06, 32'h55, 2'd2), acc(7'h05, 32'hDEAD_BEEF, 2'd3), "R8");
        scan_ir(5'h10);
        scan_dr(32, 0, ctl(2'd3), "R4");
        idle(260);
        check(req_count == 3, "R8", "request dropped while sticky", 64'(req_count), 64'd3);
        check(mem[6] == 0, "R8", "dropped write left memory", 64'(mem[6]), 64'd0);
        scan_ir(5'h11);
        scan_dr(AW, acc(0, 0, 0), acc(7'h05, 32'hDEAD_BEEF, 2'd3), "R8");
        scan_ir(5'h10);
        scan_dr(32, 64'(1) << 16, ctl(2'd3), "R9");
        scan_ir(5'h11);
        scan_dr(AW, acc(0, 0, 0), acc(7'h05, 32'hDEAD_BEEF, 0), "R9");

        // R10: failing response becomes sticky failed
        lat = 2;
        scan_dr(AW, acc(7'h7F, 0, 2'd1), acc(7'h05, 32'hDEAD_BEEF, 0), "R10");
        idle(12);
        scan_dr(AW, acc(0, 0, 0), acc(7'h7F, 0, 2'd2), "R10");
        rc = req_count;
        scan_dr(AW, acc(7'h06, 32'h1234, 2'd2), acc(7'h7F, 0, 2'd2), "R8");
        idle(12);
        check(req_count == rc, "R8", "no request while failed", 64'(req_count), 64'(rc));
        scan_ir(5'h10);
        scan_dr(32, 64'(1) << 16, ctl(2'd2), "R10");
        scan_ir(5'h11);
        scan_dr(AW, acc(0, 0, 0), acc(7'h7F, 0, 0), "R9");

        // R11: hard reset abandons the live request and discards its response
        lat = 300;
        scan_dr(AW, acc(7'h05, 0, 2'd1), acc(7'h7F, 0, 0), "R11");
        scan_ir(5'h10);
        scan_dr(32, 64'(1) << 17, ctl(2'd0), "R11");
        scan_ir(5'h11);
        scan_dr(AW, acc(0, 0, 0), acc(7'h05, 0, 2'd3), "R11");
        idle(260);
        scan_dr(AW, acc(0, 0, 0), acc(7'h05, 0, 0), "R11");
        lat = 2;

        // R12: bypass for all-ones and for an unassigned code
        scan_ir(5'h1F);
        scan_dr(8, 64'hB2, 64'h64, "R12");
        scan_ir(5'h05);
        scan_dr(8, 64'h4D, 64'h9A, "R12");

        // R1: five TMS-high clocks restore the identification instruction
        begin
            logic g; int b = 0;
            for (int i = 0; i < 5; i++) tick(1, 0, 0, g, b);
            tick(0, 0, 0, g, b);
            check(b == 0, "R1", "tdo during TMS reset", 64'(b), 64'd0);
        end
        scan_dr(32, 0, 64'(IDV), "R1");

        // R1: asynchronous test reset
        scan_ir(5'h1F);
        @(negedge tck); trst_n = 0; tms = 1;
        @(negedge tck); trst_n = 1;
        idle(1);
        scan_dr(32, 0, 64'(IDV), "R1");

        report();
        $finish;
    end
endmodule